// File: doc/BRIEF.md
# Floating-Point Divide/Square-Root Occupancy Tracker

This block keeps the structural reservation books for a non-pipelined floating-point divide/square-root unit and for the multiplier that the divider shares with ordinary multiplies. It does not compute a quotient. It only tracks which resource is held in which cycle and turns that into grant and busy signals for the issue logic.

A divide or square-root request is accepted only while the divider is free. Acceptance happens in the same cycle as the request. In the issue cycle the operation takes both the divider and the multiplier. After that it holds the divider alone for a precision-dependent stretch. It then takes the multiplier once more for one cycle to round the result, holds the divider for two more cycles, and ends with a one-cycle completion pulse. During that pulse the divider is already free, so another operation may issue back-to-back.

Independent multiply requests are granted in every cycle in which the divider does not claim the multiplier. The divider's two claims win because they were committed when the divide issued.

The operation runs through five named states:
- IDLE: nothing in flight.
- HOLD: divider held alone, counted down.
- ROUND: divider plus multiplier.
- TAIL: divider alone, counted down.
- FINISH: completion pulse, divider free.

The transitions are:
- issue: IDLE or FINISH to HOLD on an accepted request.
- hold_end: HOLD to ROUND when the count expires.
- round_end: ROUND to TAIL.
- tail_end: TAIL to FINISH.
- retire: FINISH to IDLE when no new request arrives.

Top module: `fdiv_occupancy_tracker`

## Requirements
- R1: With `div_start_dbl`=0, an accepted request (cycle 0) raises `div_done` for exactly one cycle, in cycle 12.
- R2: With `div_start_dbl`=1, an accepted request (cycle 0) raises `div_done` for exactly one cycle, in cycle 22.
- R3: `div_busy` is 1 from cycle 1 through the cycle before `div_done`, and 0 in the `div_done` cycle and while idle. `div_start_ok` equals `div_start_req` when `div_busy` is 0, and is 0 when `div_busy` is 1.
- R4: In the cycle a request is accepted, `fmul_avail` is 0, because the issuing operation claims the multiplier.
- R5: `fmul_avail` is 0 in the rounding cycle, which is 3 cycles before `div_done` (cycle 9 single, cycle 19 double). It is 1 in every other cycle after issue.
- R6: `fmul_grant` equals `fmul_req` AND `fmul_avail`. With no divide in flight, every multiply request is granted.
- R7: After reset, `div_busy`=0, `div_done`=0 and `fmul_avail`=1.
- R8: A request refused while busy has no effect: the running operation keeps its precision and its cycle timing.
- R9: A request accepted in a `div_done` cycle starts a new operation timed from that cycle with its own precision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_start_req | input | 1 | Divide/sqrt issue request |
| div_start_dbl | input | 1 | Precision of the request: 1 double, 0 single |
| fmul_req | input | 1 | Independent multiply issue request |
| div_start_ok | output | 1 | Request accepted this cycle |
| div_busy | output | 1 | Divider held by an earlier operation |
| fmul_avail | output | 1 | Multiplier free for an independent multiply this cycle |
| fmul_grant | output | 1 | Multiply request granted this cycle |
| div_done | output | 1 | Final cycle of the operation |

## Verification
The block is exercised with four kinds of traffic, and each one separates a different pair of faults:
- An isolated single-precision operation and an isolated double-precision operation, each with a multiply request held high in every cycle. These pin down the hold length, the position of the rounding claim and the completion cycle for each precision, so a swapped or shifted count shows up.
- A request with the opposite precision poked into the middle of a running operation. This shows whether a refused request leaks into the counter or the stored precision.
- A request chained into the completion cycle. This tells a divider that frees itself one cycle late from one that is correctly free in its `div_done` cycle.
- Multiply traffic with the divider idle. This confirms that the divider's claims are the only thing that blocks a multiply.

// File: rtl/fdiv_occ_pkg.sv
package fdiv_occ_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_HOLD   = 3'd1,
        PH_ROUND  = 3'd2,
        PH_TAIL   = 3'd3,
        PH_FINISH = 3'd4
    } div_phase_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fdiv_phase_fsm.sv
module fdiv_phase_fsm
    import fdiv_occ_pkg::*;
#(
    parameter int SP_HOLD_CYC = 8,
    parameter int DP_HOLD_CYC = 18,
    parameter int TAIL_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic start_dbl,
    output logic accept,
    output logic busy,
    output logic rounding,
    output logic finish
);
    localparam int CNT_MAX = max3(SP_HOLD_CYC, DP_HOLD_CYC, TAIL_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SP_LOAD   = CNT_W'(SP_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] DP_LOAD   = CNT_W'(DP_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_CYC - 1);

    div_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             can_issue;
    logic             cnt_zero;

    assign can_issue = (phase_q == PH_IDLE) || (phase_q == PH_FINISH);
    assign cnt_zero  = (cnt_q == '0);

    // next-state and counter
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE, PH_FINISH: begin
                if (start_req) begin
                    phase_d = PH_HOLD;
                    cnt_d   = start_dbl ? DP_LOAD : SP_LOAD;
                end else begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end
            end
            PH_HOLD: begin
                if (cnt_zero) begin
                    phase_d = PH_ROUND;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_ROUND: begin
                phase_d = PH_TAIL;
                cnt_d   = TAIL_LOAD;
            end
            PH_TAIL: begin
                if (cnt_zero) begin
                    phase_d = PH_FINISH;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        rounding = 1'b0;
        finish   = 1'b0;
        unique case (phase_q)
            PH_IDLE:   ;
            PH_HOLD:   busy = 1'b1;
            PH_ROUND: begin
                busy     = 1'b1;
                rounding = 1'b1;
            end
            PH_TAIL:   busy = 1'b1;
            PH_FINISH: finish = 1'b1;
            default:   ;
        endcase
        accept = start_req && can_issue;
    end

endmodule

// File: rtl/fmul_port_arb.sv
module fmul_port_arb (
    input  logic div_issue,
    input  logic div_round,
    input  logic mul_req,
    output logic mul_avail,
    output logic mul_grant
);
    // divider claims were committed at divide issue and always win
    always_comb begin
        mul_avail = !(div_issue || div_round);
        mul_grant = mul_req && mul_avail;
    end
endmodule

// File: rtl/fdiv_occupancy_tracker.sv
module fdiv_occupancy_tracker #(
    parameter int SP_HOLD_CYC = 8,
    parameter int DP_HOLD_CYC = 18,
    parameter int TAIL_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_start_req,
    input  logic div_start_dbl,
    input  logic fmul_req,
    output logic div_start_ok,
    output logic div_busy,
    output logic fmul_avail,
    output logic fmul_grant,
    output logic div_done
);
    logic accept_w;
    logic round_w;

    fdiv_phase_fsm #(
        .SP_HOLD_CYC(SP_HOLD_CYC),
        .DP_HOLD_CYC(DP_HOLD_CYC),
        .TAIL_CYC   (TAIL_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(div_start_req),
        .start_dbl(div_start_dbl),
        .accept   (accept_w),
        .busy     (div_busy),
        .rounding (round_w),
        .finish   (div_done)
    );

    fmul_port_arb u_arb (
        .div_issue(accept_w),
        .div_round(round_w),
        .mul_req  (fmul_req),
        .mul_avail(fmul_avail),
        .mul_grant(fmul_grant)
    );

    assign div_start_ok = accept_w;

endmodule

// File: rtl/fdiv_occ_checker.sv
module fdiv_occ_checker #(
    parameter int SP_HOLD_CYC = 8,
    parameter int DP_HOLD_CYC = 18,
    parameter int TAIL_CYC    = 2
) (
    input logic clk,
    input logic rst_n,
    input logic div_start_req,
    input logic div_start_dbl,
    input logic fmul_req,
    input logic div_start_ok,
    input logic div_busy,
    input logic fmul_avail,
    input logic fmul_grant,
    input logic div_done
);
    localparam int SP_LAST = SP_HOLD_CYC + TAIL_CYC + 2;
    localparam int DP_LAST = DP_HOLD_CYC + TAIL_CYC + 2;
    localparam int TW      = $clog2(((SP_LAST > DP_LAST) ? SP_LAST : DP_LAST) + 1);

    logic          trk_active;
    logic          trk_dbl;
    logic [TW-1:0] trk_cyc;
    logic [TW-1:0] last_c, round_c;

    assign last_c  = trk_dbl ? TW'(DP_LAST) : TW'(SP_LAST);
    assign round_c = trk_dbl ? TW'(DP_HOLD_CYC + 1) : TW'(SP_HOLD_CYC + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_active <= 1'b0;
            trk_dbl    <= 1'b0;
            trk_cyc    <= '0;
        end else if (div_start_ok) begin
            trk_active <= 1'b1;
            trk_dbl    <= div_start_dbl;
            trk_cyc    <= TW'(1);
        end else if (trk_active) begin
            if (trk_cyc == last_c) trk_active <= 1'b0;
            else                   trk_cyc    <= trk_cyc + 1'b1;
        end
    end

    AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_active && trk_cyc == last_c) |-> div_done);                 // R1
    AST_DONE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_active && trk_cyc != last_c) |-> !div_done);                // R2
    AST_BUSY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_active && trk_cyc != last_c) |-> div_busy);                 // R3
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !div_start_ok);                                     // R3
    AST_OK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        div_start_ok |-> div_start_req);                                 // R3
    AST_ISSUE_TAKES_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        div_start_ok |-> !fmul_avail);                                   // R4
    AST_ROUND_TAKES_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_active && trk_cyc == round_c) |-> !fmul_avail);             // R5
    AST_GRANT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fmul_grant |-> (fmul_req && fmul_avail));                        // R6
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> !div_busy);                                         // R9
    AST_START_BUSY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        div_start_ok |=> div_busy);                                      // R8

endmodule

bind fdiv_occupancy_tracker fdiv_occ_checker #(
    .SP_HOLD_CYC(SP_HOLD_CYC),
    .DP_HOLD_CYC(DP_HOLD_CYC),
    .TAIL_CYC   (TAIL_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_start_req(div_start_req),
    .div_start_dbl(div_start_dbl),
    .fmul_req     (fmul_req),
    .div_start_ok (div_start_ok),
    .div_busy     (div_busy),
    .fmul_avail   (fmul_avail),
    .fmul_grant   (fmul_grant),
    .div_done     (div_done)
);

// File: tb/sim_fdiv_occupancy_tracker.sv
`timescale 1ns/1ps
module sim_fdiv_occupancy_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div_start_req = 1'b0;
    logic div_start_dbl = 1'b0;
    logic fmul_req = 1'b0;
    logic div_start_ok, div_busy, fmul_avail, fmul_grant, div_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fdiv_occupancy_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .div_start_req(div_start_req), .div_start_dbl(div_start_dbl),
        .fmul_req(fmul_req),
        .div_start_ok(div_start_ok), .div_busy(div_busy),
        .fmul_avail(fmul_avail), .fmul_grant(fmul_grant), .div_done(div_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle 0 = acceptance cycle; poke_k injects a refused opposite-precision
    // request; chain requests a double in the done cycle; skip_start means
    // cycle 0 was already performed by the caller
    task automatic track_op(input bit dbl, input int poke_k, input bit chain,
                            input bit skip_start, input string req);
        int last_k;
        int round_k;
        last_k  = dbl ? 22 : 12;
        round_k = dbl ? 19 : 9;
        if (!skip_start) begin
            @(negedge clk);
            div_start_req = 1'b1;
            div_start_dbl = dbl;
            fmul_req      = 1'b1;
            #1;
            chk(req, "start_ok@0", div_start_ok, 1);
            chk("R4", "fmul_avail@issue", fmul_avail, 0);
            chk("R6", "fmul_grant@issue", fmul_grant, 0);
        end
        for (int k = 1; k <= last_k; k++) begin
            @(negedge clk);
            div_start_req = (k == poke_k) || (chain && k == last_k);
            div_start_dbl = (k == poke_k) ? !dbl : 1'b1;
            fmul_req      = 1'b1;
            #1;
            chk(req, $sformatf("div_done@%0d", k), div_done, (k == last_k) ? 1 : 0);
            chk("R3", $sformatf("div_busy@%0d", k), div_busy, (k == last_k) ? 0 : 1);
            chk("R5", $sformatf("fmul_avail@%0d", k), fmul_avail,
                (k == round_k || (chain && k == last_k)) ? 0 : 1);
            chk("R6", $sformatf("fmul_grant@%0d", k), fmul_grant,
                (k == round_k || (chain && k == last_k)) ? 0 : 1);
            if (k == poke_k) chk("R8", "refused start_ok", div_start_ok, 0);
            if (chain && k == last_k) chk("R9", "chained start_ok", div_start_ok, 1);
        end
        if (!chain) begin
            @(negedge clk);
            div_start_req = 1'b0;
            fmul_req      = 1'b0;
            #1;
            chk(req, "div_done after", div_done, 0);
            chk("R3", "div_busy after", div_busy, 0);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        #1;
        chk("R7", "div_busy", div_busy, 0);
        chk("R7", "div_done", div_done, 0);
        chk("R7", "fmul_avail", fmul_avail, 1);
    endtask

    task automatic test_single();
        track_op(1'b0, -1, 1'b0, 1'b0, "R1");
    endtask

    task automatic test_double();
        track_op(1'b1, -1, 1'b0, 1'b0, "R2");
    endtask

    task automatic test_refused_start();
        track_op(1'b0, 5, 1'b0, 1'b0, "R8");
        track_op(1'b1, 10, 1'b0, 1'b0, "R8");
    endtask

    task automatic test_back_to_back();
        track_op(1'b0, -1, 1'b1, 1'b0, "R9");
        track_op(1'b1, -1, 1'b0, 1'b1, "R9");
    endtask

    task automatic test_idle_mul();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fmul_req      = (i % 2 == 0);
            div_start_req = 1'b0;
            #1;
            chk("R6", "idle fmul_grant", fmul_grant, (i % 2 == 0) ? 1 : 0);
            chk("R6", "idle fmul_avail", fmul_avail, 1);
        end
        @(negedge clk);
        fmul_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_single();
        test_double();
        test_refused_start();
        test_back_to_back();
        test_idle_mul();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule